// File: doc/BRIEF.md
# Three-Phase Gate Drive Protection Core

This block is the digital heart of a three-phase half-bridge gate driver. For each of the phases U, V and W it receives an upper-switch command and a lower-switch command, all active high, and drives one gate-enable output per switch. Every command passes a two-flop synchronizer and then a minimum-width filter, so that short on-pulses and off-pulses are discarded. A phase whose two filtered commands are both active has both gates forced off.

Protection inputs gate the outputs. An over-current flag or a low-side supply undervoltage flag turns off all six gates and pulls the shared fault/enable line low. The fault does not latch. Once the cause is gone, a hold timer of `CLR_CYC` cycles runs, and after it expires drive resumes from the present commands. A per-phase high-side supply undervoltage flag turns off only that phase and never raises the fault line. The external enable level, read from the same shared line, stops all drive while it is low. Whenever the block is pulling the line low itself, it treats the enable as low.

Top module: `gate_prot_core`

## Requirements
- R1: After reset all six gate outputs are 0 and `flt_pull_o` is 0 (line released).
- R2: If both filtered commands of a phase are 1, that phase's `gate_hi_o` and `gate_lo_o` bits are both 0, and other phases still follow their commands (bit 0 = U, bit 1 = V, bit 2 = W).
- R3: When `oc_i` is 1, all gate outputs go to 0 and `flt_pull_o` goes to 1, three clock edges after the flag is sampled.
- R4: After the fault cause has cleared, `flt_pull_o` stays 1 for `CLR_CYC` further cycles and then returns to 0, after which the gates follow the commands again with no other action. A new fault during the hold restarts the timer.
- R5: While `uv_lo_i` is 1, all gate outputs are 0 and `flt_pull_o` is 1 for the whole time.
- R6: `uv_hi_i[n]` = 1 forces both gates of phase n to 0, leaves the other phases unchanged and never sets `flt_pull_o`.
- R7: `en_i` = 0 forces all gates to 0 without setting `flt_pull_o`. With `en_i` = 1 the gates follow the commands.
- R8: A command level held for fewer than `FILT_CYC` cycles (an on-pulse or an off-pulse) does not change the gate output. A level held for at least `FILT_CYC` cycles does change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hin_i | input | 3 | Upper-switch commands, one bit per phase |
| lin_i | input | 3 | Lower-switch commands, one bit per phase |
| oc_i | input | 1 | Over-current comparator flag |
| uv_lo_i | input | 1 | Low-side supply undervoltage flag |
| uv_hi_i | input | 3 | Per-phase high-side supply undervoltage flags |
| en_i | input | 1 | Level observed on the shared fault/enable line |
| flt_pull_o | output | 1 | 1 = pull the shared line low (fault indication) |
| gate_hi_o | output | 3 | Upper-switch gate enables |
| gate_lo_o | output | 3 | Lower-switch gate enables |

## Verification
Fault recovery and fault detection can fall in the same cycle: the hold timer can be about to expire just as a new over-current arrives. The bench releases over-current and then raises it again a few cycles before the hold would end. It judges the result by requiring that the fault line never drops in between and that release comes only one full hold period after the second fault clears. Random command, enable and high-side undervoltage mixes run alongside this, each checked against a bench model of the gate outputs.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  localparam int unsigned N_PH = 3;
  // synchronized status bits: {en, uv_lo, oc, uv_hi[2:0], lin[2:0], hin[2:0]}
  localparam int unsigned N_SYNC = 3 * N_PH + 3;
endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpc_min_width.sv
module gpc_min_width #(
  parameter int unsigned W    = 6,
  parameter int unsigned FILT = 200
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned CW = $clog2(FILT + 1);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    // output follows input only after FILT consecutive differing samples
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        lvl_q <= 1'b0;
      end else if (d_i[g] != lvl_q) begin
        if (cnt_q == CW'(FILT - 1)) begin
          lvl_q <= d_i[g];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end

    assign q_o[g] = lvl_q;
  end
endmodule

// File: rtl/gpc_fault_ctl.sv
module gpc_fault_ctl #(
  parameter int unsigned CLR = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  output logic hold_o
);
  localparam int unsigned CW = $clog2(CLR + 1);

  logic          hold_q;
  logic [CW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      tmr_q  <= '0;
    end else if (cause_i) begin
      hold_q <= 1'b1;
      tmr_q  <= '0;
    end else if (hold_q) begin
      if (tmr_q == CW'(CLR - 1)) begin
        hold_q <= 1'b0;
        tmr_q  <= '0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/gate_prot_core.sv
module gate_prot_core
  import gpc_pkg::*;
#(
  parameter int unsigned FILT_CYC = 200,
  parameter int unsigned CLR_CYC  = 200000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_PH-1:0] hin_i,
  input  logic [N_PH-1:0] lin_i,
  input  logic            oc_i,
  input  logic            uv_lo_i,
  input  logic [N_PH-1:0] uv_hi_i,
  input  logic            en_i,
  output logic            flt_pull_o,
  output logic [N_PH-1:0] gate_hi_o,
  output logic [N_PH-1:0] gate_lo_o
);
  logic [N_SYNC-1:0] sync_q;
  logic [N_PH-1:0]   hin_s, lin_s, uvh_s, hin_f, lin_f;
  logic              oc_s, uvl_s, en_s, cause, hold, allow;
  logic [N_PH-1:0]   ghi_q, glo_q;

  gpc_sync #(.W(N_SYNC)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({en_i, uv_lo_i, oc_i, uv_hi_i, lin_i, hin_i}),
    .q_o    (sync_q)
  );

  assign {en_s, uvl_s, oc_s, uvh_s, lin_s, hin_s} = sync_q;

  gpc_min_width #(.W(2 * N_PH), .FILT(FILT_CYC)) i_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({lin_s, hin_s}),
    .q_o    ({lin_f, hin_f})
  );

  assign cause = oc_s | uvl_s;

  gpc_fault_ctl #(.CLR(CLR_CYC)) i_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cause_i (cause),
    .hold_o  (hold)
  );

  // own pull-down masks the observed enable level
  assign allow = en_s & ~hold & ~cause;

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    logic ph_ok;
    assign ph_ok = allow & ~uvh_s[p] & ~(hin_f[p] & lin_f[p]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ghi_q[p] <= 1'b0;
        glo_q[p] <= 1'b0;
      end else begin
        ghi_q[p] <= ph_ok & hin_f[p];
        glo_q[p] <= ph_ok & lin_f[p];
      end
    end
  end

  assign gate_hi_o  = ghi_q;
  assign gate_lo_o  = glo_q;
  assign flt_pull_o = hold;
endmodule

// File: rtl/gpc_checker.sv
module gpc_checker
  import gpc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            oc_i,
  input logic            uv_lo_i,
  input logic [N_PH-1:0] uv_hi_i,
  input logic            en_i,
  input logic            flt_pull_o,
  input logic [N_PH-1:0] gate_hi_o,
  input logic [N_PH-1:0] gate_lo_o
);
  p_no_shoot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_hi_o & gate_lo_o) == '0);

  p_fault_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_pull_o |-> (gate_hi_o == '0 && gate_lo_o == '0));

  p_fault_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flt_pull_o) |-> $past(oc_i | uv_lo_i, 3));

  p_uvlo_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(uv_lo_i, 3) |-> flt_pull_o);

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    p_uvhi_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_hi_o[p] | gate_lo_o[p]) |-> !$past(uv_hi_i[p], 3));
  end

  p_enable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{gate_hi_o, gate_lo_o}) |-> $past(en_i, 3));
endmodule

bind gate_prot_core gpc_checker i_gpc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .oc_i       (oc_i),
  .uv_lo_i    (uv_lo_i),
  .uv_hi_i    (uv_hi_i),
  .en_i       (en_i),
  .flt_pull_o (flt_pull_o),
  .gate_hi_o  (gate_hi_o),
  .gate_lo_o  (gate_lo_o)
);

// File: tb/test_gate_prot_core.sv
module test_gate_prot_core;
  localparam int unsigned FILT = 6;
  localparam int unsigned CLR  = 40;
  localparam int unsigned SETL = FILT + 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] hin_i = '0, lin_i = '0, uv_hi_i = '0;
  logic       oc_i = 1'b0, uv_lo_i = 1'b0, en_i = 1'b1;
  logic       flt_pull_o;
  logic [2:0] gate_hi_o, gate_lo_o;

  int checks = 0;
  int errors = 0;
  int unsigned seed_v;

  always #2.5 clk_i = ~clk_i;

  gate_prot_core #(.FILT_CYC(FILT), .CLR_CYC(CLR)) i_gate_prot_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .hin_i(hin_i), .lin_i(lin_i),
    .oc_i(oc_i), .uv_lo_i(uv_lo_i), .uv_hi_i(uv_hi_i), .en_i(en_i),
    .flt_pull_o(flt_pull_o), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // expected {gate_hi, gate_lo} for stable inputs and no fault
  function automatic logic [5:0] model(input logic [2:0] h, input logic [2:0] l,
                                       input logic [2:0] uvh, input logic en);
    logic [2:0] ok;
    ok = {3{en}} & ~uvh & ~(h & l);
    return {ok & h, ok & l};
  endfunction

  initial begin
    int unsigned wd = 0;
    forever begin
      @(posedge clk_i);
      wd++;
      if (wd > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    bit seen;
    bit held;
    seed_v = 32'h5eed_2024;
    void'($urandom(seed_v));
    tick(3);
    // R1 reset state
    check("R1 flag", {7'd0, flt_pull_o}, 8'd0);
    check("R1 gates", {2'd0, gate_hi_o, gate_lo_o}, 8'd0);
    rst_ni = 1'b1;
    tick(SETL);
    check("R1 after release", {1'b0, flt_pull_o, gate_hi_o, gate_lo_o}, 8'd0);

    // R2 shoot-through on W, U upper only, V lower only
    hin_i = 3'b101; lin_i = 3'b110;
    tick(SETL);
    check("R2 gates", {2'd0, gate_hi_o, gate_lo_o}, {2'd0, 3'b001, 3'b010});

    // R8 short on-pulse ignored, long one passes
    hin_i = '0; lin_i = '0;
    tick(SETL);
    hin_i[0] = 1'b1; tick(FILT - 2); hin_i[0] = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 2 * SETL; i++) begin tick(1); if (gate_hi_o[0]) seen = 1'b1; end
    check("R8 short on-pulse", {7'd0, seen}, 8'd0);
    hin_i[0] = 1'b1; tick(FILT + 2); hin_i[0] = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 2 * SETL; i++) begin tick(1); if (gate_hi_o[0]) seen = 1'b1; end
    check("R8 long on-pulse", {7'd0, seen}, 8'd1);
    // R8 short off-pulse ignored
    lin_i[1] = 1'b1; tick(SETL);
    lin_i[1] = 1'b0; tick(FILT - 2); lin_i[1] = 1'b1;
    held = 1'b1;
    for (int i = 0; i < 2 * SETL; i++) begin tick(1); if (!gate_lo_o[1]) held = 1'b0; end
    check("R8 short off-pulse", {7'd0, held}, 8'd1);

    // R6 high-side undervoltage on V only
    hin_i = 3'b101; lin_i = 3'b010; uv_hi_i = 3'b010;
    tick(SETL);
    check("R6 gates", {2'd0, gate_hi_o, gate_lo_o}, {2'd0, 3'b101, 3'b000});
    check("R6 flag", {7'd0, flt_pull_o}, 8'd0);
    uv_hi_i = '0; tick(SETL);
    check("R6 restore", {2'd0, gate_hi_o, gate_lo_o}, {2'd0, 3'b101, 3'b010});

    // R7 enable low
    en_i = 1'b0; tick(SETL);
    check("R7 gates", {2'd0, gate_hi_o, gate_lo_o}, 8'd0);
    check("R7 flag", {7'd0, flt_pull_o}, 8'd0);
    en_i = 1'b1; tick(SETL);
    check("R7 restore", {2'd0, gate_hi_o, gate_lo_o}, {2'd0, 3'b101, 3'b010});

    // R3 over-current, R4 timed recovery
    oc_i = 1'b1; tick(1); oc_i = 1'b0;
    tick(3);
    check("R3 flag", {7'd0, flt_pull_o}, 8'd1);
    check("R3 gates", {2'd0, gate_hi_o, gate_lo_o}, 8'd0);
    tick(CLR - 8);
    check("R4 still held", {7'd0, flt_pull_o}, 8'd1);
    tick(10);
    check("R4 released", {7'd0, flt_pull_o}, 8'd0);
    check("R4 gates resume", {2'd0, gate_hi_o, gate_lo_o}, {2'd0, 3'b101, 3'b010});

    // R4 retrigger just before expiry
    oc_i = 1'b1; tick(1); oc_i = 1'b0;
    tick(CLR - 3);
    oc_i = 1'b1; tick(1); oc_i = 1'b0;
    held = 1'b1;
    for (int i = 0; i < CLR - 5; i++) begin tick(1); if (!flt_pull_o) held = 1'b0; end
    check("R4 retrigger hold", {7'd0, held}, 8'd1);
    tick(12);
    check("R4 retrigger release", {7'd0, flt_pull_o}, 8'd0);

    // R5 low-side undervoltage longer than hold time
    uv_lo_i = 1'b1; tick(4);
    held = 1'b1;
    for (int i = 0; i < 2 * CLR; i++) begin
      tick(1);
      if (!flt_pull_o || gate_hi_o != 0 || gate_lo_o != 0) held = 1'b0;
    end
    check("R5 held throughout", {7'd0, held}, 8'd1);
    uv_lo_i = 1'b0; tick(CLR + 8);
    check("R5 released", {1'b0, flt_pull_o, gate_hi_o, gate_lo_o}, {2'd0, 3'b101, 3'b010});

    // random mixes: R2 R6 R7
    for (int k = 0; k < 40; k++) begin
      hin_i = 3'($urandom);
      lin_i = 3'($urandom);
      uv_hi_i = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      en_i = (($urandom % 4) != 0);
      tick(SETL);
      check("R2/R6/R7 random", {2'd0, gate_hi_o, gate_lo_o},
            {2'd0, model(hin_i, lin_i, uv_hi_i, en_i)});
      check("R6/R7 random flag", {7'd0, flt_pull_o}, 8'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule